// File: doc/BRIEF.md
# Audio master, bit and frame clock generator

This block produces the three clocks of a serial audio port from one core clock: a master clock for an external converter, a bit clock and a frame (left/right) clock. A family bit gives the base rate. With the bit clear, the serial clock runs at 512 times the sample rate. With the bit set, it runs at 384 times the sample rate. The core clock input runs at twice that serial rate (1024 fs or 768 fs). Every output is therefore a registered square wave, and the full-rate master clock needs no gated clock. The dividers are pure integer ratios, so the same logic serves any sample rate from 8 kHz to 192 kHz. Only the core clock frequency changes.

A 3-bit ratio code picks the master clock oversample ratio within the selected family. A run bit enables the master clock. A ratio or run change never cuts a high phase short. In master mode the bit clock and frame clock are built locally while run is set. In follower mode they are passed through from a peer port, the local generator is held in reset, and the core clock keeps clocking the logic.

Top module: `audio_clk_gen`

## Requirements
- R1: With family bit 0, ratio codes 0, 1, 2, 3 and 4 give a master clock whose high and low phases each last 1, 2, 4, 8 and 16 core clocks. This corresponds to 512, 256, 128, 64 and 32 fs.
- R2: With family bit 1, ratio codes 0, 1, 2 and 3 give master clock phases of 1, 2, 4 and 8 core clocks. This corresponds to 384, 192, 96 and 48 fs.
- R3: Ratio codes 5, 6 and 7 in either family, and code 4 with family bit 1, hold the master clock low.
- R4: When run is 0, the master clock finishes any high phase at full length and then stays low. In master mode the bit clock and frame clock are also held low.
- R5: A ratio change during a high phase lets that phase run to its full old length, and the new ratio starts at the falling edge. A change during a low phase restarts the count on the next clock, so the low phase lasts the time already spent plus one full new phase.
- R6: In master mode with run set, the bit clock has 8 core clocks high and 8 low. It is first seen high on the 8th clock after run is applied.
- R7: The frame clock has a 50% duty cycle. It changes only in the cycle where the bit clock falls, and each phase lasts 32 bit clocks (512 core clocks) with family bit 0, or 24 bit clocks (384 core clocks) with family bit 1.
- R8: With the follower select set, the bit clock and frame clock outputs equal the peer inputs in the same cycle. The master clock keeps running at its selected ratio.
- R9: During reset, all three clock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, 1024 fs or 768 fs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_384_i | input | 1 | Family bit: 0 for 512 fs base, 1 for 384 fs base |
| mult_code_i | input | CODE_W | Master clock ratio code |
| run_i | input | 1 | Enables the master clock and the local bit/frame clocks |
| slave_i | input | 1 | Follower select: bit and frame clocks come from the peer |
| peer_bclk_i | input | 1 | Bit clock from the peer port |
| peer_fclk_i | input | 1 | Frame clock from the peer port |
| mclk_o | output | 1 | Master clock to the converter |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |

## Verification
A new ratio request can arrive in the same cycle that the master clock reaches the end of a high phase. In that case, completing the old phase and adopting the new ratio happen at one edge. The bench changes the code partway through a high phase and partway through a low phase. It judges by the measured length of the phase in flight (16 and 12 cycles) and by the period that follows. The frame toggle and the bit clock falling edge also share one cycle by design. Every frame transition is checked against a bit clock falling edge sampled at the same point.

// File: rtl/acg_pkg.sv
package acg_pkg;

    // Base-rate family of the serial clock
    typedef enum logic {
        FAM_512 = 1'b0,
        FAM_384 = 1'b1
    } fam_e;

endpackage

// File: rtl/acg_mclk_div.sv
module acg_mclk_div
    import acg_pkg::*;
#(
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned MAX_CODE_A = 4,
    parameter int unsigned MAX_CODE_B = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  fam_e              fam_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              run_i,
    output logic              mclk_o
);

    localparam int unsigned MAX_CODE = (MAX_CODE_A > MAX_CODE_B) ? MAX_CODE_A : MAX_CODE_B;
    localparam int unsigned CNT_W    = (MAX_CODE > 0) ? MAX_CODE : 1;

    typedef struct packed {
        logic              mclk;
        logic              act_vld;
        logic [CODE_W-1:0] act_code;
        logic [CNT_W-1:0]  cnt;
    } mdiv_t;

    mdiv_t            div_d, div_q;
    logic             req_vld;
    logic             cfg_diff;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        if (fam_i == FAM_384) begin
            req_vld = run_i && (code_i <= CODE_W'(MAX_CODE_B));
        end else begin
            req_vld = run_i && (code_i <= CODE_W'(MAX_CODE_A));
        end
        cfg_diff = (req_vld != div_q.act_vld) ||
                   (req_vld && (code_i != div_q.act_code));
        last_cnt = CNT_W'((32'd1 << div_q.act_code) - 32'd1);

        div_d = div_q;
        if (div_q.mclk) begin
            // a high phase always completes with the ratio it began with
            if (div_q.cnt == last_cnt) begin
                div_d.mclk     = 1'b0;
                div_d.cnt      = '0;
                div_d.act_vld  = req_vld;
                div_d.act_code = req_vld ? code_i : '0;
            end else begin
                div_d.cnt = div_q.cnt + CNT_W'(1);
            end
        end else if (cfg_diff) begin
            // low phase: take the new setting and restart counting
            div_d.cnt      = '0;
            div_d.act_vld  = req_vld;
            div_d.act_code = req_vld ? code_i : '0;
        end else if (div_q.act_vld) begin
            if (div_q.cnt == last_cnt) begin
                div_d.mclk = 1'b1;
                div_d.cnt  = '0;
            end else begin
                div_d.cnt = div_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign mclk_o = div_q.mclk;

endmodule

// File: rtl/acg_frame_gen.sv
module acg_frame_gen
    import acg_pkg::*;
#(
    parameter int unsigned BCLK_HALF   = 8,
    parameter int unsigned HALF_BITS_A = 32,
    parameter int unsigned HALF_BITS_B = 24
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  fam_e fam_i,
    output logic bclk_o,
    output logic fclk_o
);

    localparam int unsigned BC_W     = $clog2(2 * BCLK_HALF);
    localparam int unsigned MAX_BITS = (HALF_BITS_A > HALF_BITS_B) ? HALF_BITS_A : HALF_BITS_B;
    localparam int unsigned BIT_W    = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    typedef struct packed {
        logic             bclk;
        logic             fclk;
        logic [BC_W-1:0]  bc;
        logic [BIT_W-1:0] bits;
    } fgen_t;

    fgen_t            gen_d, gen_q;
    logic [BIT_W-1:0] bits_last;

    always_comb begin
        bits_last = (fam_i == FAM_384) ? BIT_W'(HALF_BITS_B - 1) : BIT_W'(HALF_BITS_A - 1);
        gen_d     = gen_q;
        if (!en_i) begin
            gen_d = '0;
        end else if (gen_q.bc == BC_W'(2 * BCLK_HALF - 1)) begin
            // bit clock falls; frame clock may move in the same cycle
            gen_d.bc   = '0;
            gen_d.bclk = 1'b0;
            if (gen_q.bits >= bits_last) begin
                gen_d.bits = '0;
                gen_d.fclk = ~gen_q.fclk;
            end else begin
                gen_d.bits = gen_q.bits + BIT_W'(1);
            end
        end else begin
            gen_d.bc = gen_q.bc + BC_W'(1);
            if (gen_q.bc == BC_W'(BCLK_HALF - 1)) begin
                gen_d.bclk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign bclk_o = gen_q.bclk;
    assign fclk_o = gen_q.fclk;

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
    import acg_pkg::*;
#(
    parameter int unsigned CODE_W      = 3,
    parameter int unsigned MAX_CODE_A  = 4,
    parameter int unsigned MAX_CODE_B  = 3,
    parameter int unsigned BCLK_HALF   = 8,
    parameter int unsigned HALF_BITS_A = 32,
    parameter int unsigned HALF_BITS_B = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              base_384_i,
    input  logic [CODE_W-1:0] mult_code_i,
    input  logic              run_i,
    input  logic              slave_i,
    input  logic              peer_bclk_i,
    input  logic              peer_fclk_i,
    output logic              mclk_o,
    output logic              bclk_o,
    output logic              fclk_o
);

    fam_e fam;
    logic gen_en;
    logic loc_bclk;
    logic loc_fclk;

    assign fam    = fam_e'(base_384_i);
    assign gen_en = run_i && !slave_i;

    acg_mclk_div #(
        .CODE_W     (CODE_W),
        .MAX_CODE_A (MAX_CODE_A),
        .MAX_CODE_B (MAX_CODE_B)
    ) i_mclk_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .fam_i  (fam),
        .code_i (mult_code_i),
        .run_i  (run_i),
        .mclk_o (mclk_o)
    );

    acg_frame_gen #(
        .BCLK_HALF   (BCLK_HALF),
        .HALF_BITS_A (HALF_BITS_A),
        .HALF_BITS_B (HALF_BITS_B)
    ) i_frame_gen (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (gen_en),
        .fam_i  (fam),
        .bclk_o (loc_bclk),
        .fclk_o (loc_fclk)
    );

    always_comb begin
        if (slave_i) begin
            bclk_o = peer_bclk_i;
            fclk_o = peer_fclk_i;
        end else begin
            bclk_o = loc_bclk;
            fclk_o = loc_fclk;
        end
    end

endmodule

// File: rtl/acg_checker.sv
module acg_checker #(
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned MAX_CODE_A = 4,
    parameter int unsigned MAX_CODE_B = 3,
    parameter int unsigned BCLK_HALF  = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              base_384_i,
    input logic [CODE_W-1:0] mult_code_i,
    input logic              run_i,
    input logic              slave_i,
    input logic              mclk_o,
    input logic              bclk_o,
    input logic              fclk_o
);

    localparam int unsigned MAX_CODE = (MAX_CODE_A > MAX_CODE_B) ? MAX_CODE_A : MAX_CODE_B;

    logic [7:0] mhi_q;
    logic [7:0] bhi_q;
    logic       mclk_off;

    assign mclk_off = !run_i ||
                      (base_384_i ? (mult_code_i > CODE_W'(MAX_CODE_B))
                                  : (mult_code_i > CODE_W'(MAX_CODE_A)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mhi_q <= '0;
            bhi_q <= '0;
        end else begin
            mhi_q <= mclk_o ? mhi_q + 8'd1 : 8'd0;
            bhi_q <= (bclk_o && !slave_i) ? bhi_q + 8'd1 : 8'd0;
        end
    end

    // R3 R4
    mclk_held_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mclk_o && mclk_off) |=> !mclk_o);

    // R5
    no_runt_mclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mclk_o) |-> (($countones(mhi_q) == 1) && (mhi_q <= 8'(1 << MAX_CODE))));

    // R6
    bclk_high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(bclk_o) && !slave_i && $past(!slave_i) && $past(run_i))
        |-> (bhi_q == 8'(BCLK_HALF)));

    // R7
    fclk_on_bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!slave_i && $past(!slave_i) && $past(run_i) && (fclk_o != $past(fclk_o)))
        |-> $fell(bclk_o));

endmodule

bind audio_clk_gen acg_checker #(
    .CODE_W     (CODE_W),
    .MAX_CODE_A (MAX_CODE_A),
    .MAX_CODE_B (MAX_CODE_B),
    .BCLK_HALF  (BCLK_HALF)
) i_acg_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_384_i  (base_384_i),
    .mult_code_i (mult_code_i),
    .run_i       (run_i),
    .slave_i     (slave_i),
    .mclk_o      (mclk_o),
    .bclk_o      (bclk_o),
    .fclk_o      (fclk_o)
);

// File: tb/test_audio_clk_gen.sv
module test_audio_clk_gen;

    localparam int CLK_PERIOD  = 10;
    localparam int WDOG_CYCLES = 150000;
    localparam int NV          = 13;
    // family bit, ratio code, expected phase length (0 = held low)
    localparam int V_BASE [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0, 1};
    localparam int V_CODE [NV] = '{0, 1, 2, 3, 4, 0, 1, 2, 3, 4, 5, 7, 6};
    localparam int V_HALF [NV] = '{1, 2, 4, 8, 16, 1, 2, 4, 8, 0, 0, 0, 0};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       base_384;
    logic [2:0] code;
    logic       run;
    logic       slave;
    logic       peer_b;
    logic       peer_f;
    logic       mclk;
    logic       bclk;
    logic       fclk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    audio_clk_gen i_audio_clk_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .base_384_i  (base_384),
        .mult_code_i (code),
        .run_i       (run),
        .slave_i     (slave),
        .peer_bclk_i (peer_b),
        .peer_fclk_i (peer_f),
        .mclk_o      (mclk),
        .bclk_o      (bclk),
        .fclk_o      (fclk)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_mclk(input logic lvl);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mclk == lvl) break;
        end
    endtask

    task automatic measure_mclk(input int exp_half, input string req, input int nsamp);
        logic prev;
        int   run_len = 1;
        int   nruns   = 0;
        int   bad     = 0;
        int   badv    = 0;
        bit   edge_seen = 1'b0;
        @(negedge clk);
        prev = mclk;
        for (int i = 1; i < nsamp; i++) begin
            @(negedge clk);
            if (mclk == prev) begin
                run_len++;
            end else begin
                if (edge_seen) begin
                    nruns++;
                    if (run_len != exp_half) begin
                        bad++;
                        badv = run_len;
                    end
                end
                edge_seen = 1'b1;
                prev      = mclk;
                run_len   = 1;
            end
        end
        if (exp_half == 0) begin
            check(!edge_seen && (prev == 1'b0), req, "mclk held low (edges seen)",
                  int'(edge_seen), 0);
        end else begin
            check(nruns >= 2, req, "mclk complete phases", nruns, 2);
            check(bad == 0, req, "mclk phase length", badv, exp_half);
        end
    endtask

    task automatic measure_frame(input int exp_b, input int exp_f, input int nsamp);
        logic pb;
        logic pf;
        int   blen = 1;
        int   flen = 1;
        int   bad_b = 0;
        int   bad_bv = 0;
        int   bad_f = 0;
        int   bad_fv = 0;
        int   nf = 0;
        int   bad_align = 0;
        bit   b_seen = 1'b0;
        bit   f_seen = 1'b0;
        @(negedge clk);
        pb = bclk;
        pf = fclk;
        for (int i = 1; i < nsamp; i++) begin
            @(negedge clk);
            if (fclk != pf) begin
                if (!(pb == 1'b1 && bclk == 1'b0)) bad_align++;
                if (f_seen) begin
                    nf++;
                    if (flen != exp_f) begin
                        bad_f++;
                        bad_fv = flen;
                    end
                end
                f_seen = 1'b1;
                flen   = 1;
            end else begin
                flen++;
            end
            if (bclk != pb) begin
                if (b_seen && blen != exp_b) begin
                    bad_b++;
                    bad_bv = blen;
                end
                b_seen = 1'b1;
                blen   = 1;
            end else begin
                blen++;
            end
            pb = bclk;
            pf = fclk;
        end
        check(bad_b == 0, "R6", "bclk phase length", bad_bv, exp_b);
        check(nf >= 2, "R7", "fclk complete phases", nf, 2);
        check(bad_f == 0, "R7", "fclk phase length", bad_fv, exp_f);
        check(bad_align == 0, "R7", "fclk moves off a bclk fall", bad_align, 0);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG_CYCLES, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        int bad;
        rst_n    = 1'b0;
        base_384 = 1'b0;
        code     = 3'd0;
        run      = 1'b0;
        slave    = 1'b0;
        peer_b   = 1'b0;
        peer_f   = 1'b0;
        repeat (5) @(negedge clk);
        // R9 reset state
        check(mclk == 1'b0, "R9", "mclk in reset", int'(mclk), 0);
        check(bclk == 1'b0, "R9", "bclk in reset", int'(bclk), 0);
        check(fclk == 1'b0, "R9", "fclk in reset", int'(fclk), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check((mclk | bclk | fclk) == 1'b0, "R4", "outputs idle with run low",
              int'({mclk, bclk, fclk}), 0);

        // ratio table: R1, R2, R3
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            base_384 = V_BASE[i][0];
            code     = V_CODE[i][2:0];
            run      = 1'b1;
            repeat (40) @(negedge clk);
            if (V_HALF[i] == 0)        measure_mclk(0, "R3", 80);
            else if (V_BASE[i] == 0)   measure_mclk(V_HALF[i], "R1", 80);
            else                       measure_mclk(V_HALF[i], "R2", 80);
        end

        // R5 change during a high phase: old phase keeps 16 cycles
        base_384 = 1'b0;
        code     = 3'd4;
        repeat (60) @(negedge clk);
        wait_mclk(1'b0);
        wait_mclk(1'b1);
        cnt = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (mclk) cnt++;
        end
        code = 3'd0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mclk) cnt++;
            else break;
        end
        check(cnt == 16, "R5", "high phase across ratio change", cnt, 16);
        measure_mclk(1, "R5", 40);

        // R5 change during a low phase: 4 elapsed + 8 new
        code = 3'd4;
        repeat (60) @(negedge clk);
        wait_mclk(1'b1);
        wait_mclk(1'b0);
        cnt = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (!mclk) cnt++;
        end
        code = 3'd3;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (!mclk) cnt++;
            else break;
        end
        check(cnt == 12, "R5", "low phase across ratio change", cnt, 12);
        cnt = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mclk) cnt++;
            else break;
        end
        check(cnt == 8, "R5", "first high phase of new ratio", cnt, 8);

        // R4 run drop during a high phase
        code = 3'd4;
        repeat (60) @(negedge clk);
        wait_mclk(1'b0);
        wait_mclk(1'b1);
        cnt = 1;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            if (mclk) cnt++;
        end
        run = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (mclk) cnt++;
            else break;
        end
        check(cnt == 16, "R4", "high phase completes after run drop", cnt, 16);
        bad = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (mclk | bclk | fclk) bad++;
        end
        check(bad == 0, "R4", "clocks high while stopped", bad, 0);

        // R6 start latency and R7 frame, family 0
        code = 3'd0;
        run  = 1'b1;
        cnt  = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            cnt++;
            if (bclk) break;
        end
        check(cnt == 8, "R6", "bclk first high after run", cnt, 8);
        measure_frame(8, 512, 1700);

        // family 1
        run = 1'b0;
        repeat (5) @(negedge clk);
        base_384 = 1'b1;
        run      = 1'b1;
        measure_frame(8, 384, 1300);

        // R8 follower mode
        base_384 = 1'b0;
        code     = 3'd2;
        slave    = 1'b1;
        bad      = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            peer_b = k[0];
            peer_f = k[1];
            #1;
            if (bclk != peer_b || fclk != peer_f) bad++;
        end
        check(bad == 0, "R8", "peer clocks passed through", bad, 0);
        measure_mclk(4, "R8", 60);
        slave = 1'b0;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule